// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Demodulator

This block recovers a tag response that arrives as on-off keying of a subcarrier. A thresholded copy of the received envelope is sampled on every tick. The block counts how often that copy changes level inside fixed bit windows, and each window yields one decoded bit. The windows are timed from a start strobe that marks the end of the reader's outgoing frame. After a fixed settling offset, the windows follow each other back to back.

The response carries no start marker, stop marker or length field. The caller therefore states how many bits to collect, and also supplies a precomputed keystream word. The result register is seeded with that keystream, and each window that decodes as a 1 flips its bit. This removes the cipher without a separate XOR stage.

A second mode searches for an acknowledge. It scans consecutive windows until the first one that decodes as a 1 and reports how many bit periods have passed. If no 1 appears within the scan limit, it reports a timeout. Silence on the input and a response of all zeros look the same to this block.

Top module: `sc_edge_demod`

## Requirements
- R1: After reset, busy_o, done_o, data_o, ack_hit_o, ack_miss_o and ack_periods_o are all zero.
- R2: The first window begins after 490 ticks counted from the cycle in which start_i is sampled, and every window spans 150 ticks. done_o rises right after the tick that closes the last window, which is 490 + 150*n ticks after start. With n = 0 it rises after 490 ticks.
- R3: A window holding more than 20 and fewer than 60 level changes decodes as 1. Any other count, including exactly 20 or exactly 60, decodes as 0. A level change is counted on a tick where rx_i differs from its value at the previous tick.
- R4: The per-window change counter stops at 127 instead of wrapping, so 149 changes in one window decode as 0.
- R5: The number of bits taken is nbits_i, limited to 32. Window k sets bit k, with bit 0 first. Bits at or above the taken count read 0.
- R6: In normal mode, data_o is seeded with key_i masked to the taken bit count, and a window decoding as 1 inverts its bit.
- R7: An input with no level changes gives data_o equal to the masked key; no bit is inverted.
- R8: With ack_mode_i set at start, the first window k that decodes as 1 ends the search. done_o rises 490 + 150*(k+1) ticks after start, with ack_hit_o = 1 and ack_periods_o = k+1. Later windows have no effect.
- R9: In ack mode, if none of 80 windows decodes as 1, done_o rises after 490 + 80*150 ticks with ack_miss_o = 1 and ack_hit_o = 0.
- R10: Timing advances only on ticks. A start_i while busy restarts timing and clears all decoding state. While idle, rx_i changes neither data_o nor done_o.
- R11: done_o is a single-cycle pulse. busy_o is high from the cycle after start until done_o, and low when done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timing tick enable; input sampled on ticks |
| start_i | input | 1 | End of reader frame; starts reception |
| ack_mode_i | input | 1 | Select acknowledge search at start |
| nbits_i | input | 6 | Requested bit count, limited to 32 |
| key_i | input | 32 | Keystream mask, bit 0 for the first window |
| rx_i | input | 1 | Thresholded subcarrier level |
| busy_o | output | 1 | Reception in progress |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | 32 | Decoded word, held until the next start |
| ack_hit_o | output | 1 | Acknowledge found |
| ack_miss_o | output | 1 | Acknowledge search timed out |
| ack_periods_o | output | 7 | Bit periods elapsed up to and including the hit |

## Verification
Window change counts are placed just inside and just outside the decision band: 0, 1, 20, 21, 42, 59, 60 and 149. This separates strict from inclusive bounds, and saturation from wraparound. A silent input and random keys show that the keystream seed is preserved and that only detected ones flip bits. Random counts across all 32 windows check bit order and the clamp on the requested length. Acknowledge runs compare an early hit that is followed by further ones against an input that never produces a 1. Held-off ticks, a restart part way through a frame, and rx_i activity while idle show that timing depends only on ticks and start_i.

// File: rtl/sc_demod_pkg.sv
`timescale 1ns/1ps
package sc_demod_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OFS  = 2'd1,
    ST_WIN  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/sc_win_timer.sv
`timescale 1ns/1ps
module sc_win_timer #(
  parameter int unsigned OFS_TICKS = 490,
  parameter int unsigned WIN_TICKS = 150,
  localparam int unsigned TW = $clog2(((OFS_TICKS > WIN_TICKS) ? OFS_TICKS : WIN_TICKS) + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  output logic in_win_o,
  output logic ofs_end_o,
  output logic win_end_o
);
  localparam logic [TW-1:0] OFS_LAST = TW'(OFS_TICKS - 1);
  localparam logic [TW-1:0] WIN_LAST = TW'(WIN_TICKS - 1);

  logic [TW-1:0] cnt_q;
  logic          in_win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      in_win_q <= 1'b0;
    end else if (clr_i || !run_i) begin
      cnt_q    <= '0;
      in_win_q <= 1'b0;
    end else if (tick_i) begin
      if (!in_win_q) begin
        if (cnt_q == OFS_LAST) begin
          cnt_q    <= '0;
          in_win_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (cnt_q == WIN_LAST) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign in_win_o  = in_win_q;
  assign ofs_end_o = run_i && !clr_i && tick_i && !in_win_q && (cnt_q == OFS_LAST);
  assign win_end_o = run_i && !clr_i && tick_i &&  in_win_q && (cnt_q == WIN_LAST);
endmodule

// File: rtl/sc_edge_count.sv
`timescale 1ns/1ps
module sc_edge_count #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             rx_i,
  input  logic             en_i,
  input  logic             win_end_i,
  output logic [CNT_W-1:0] cnt_nx_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             bump;

  // level change seen on this tick, counted only inside a window and below the ceiling
  assign bump     = tick_i && en_i && (rx_i != prev_q) && (cnt_q != CNT_MAX);
  assign cnt_nx_o = bump ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (tick_i) prev_q <= rx_i;
      if (win_end_i) cnt_q <= '0;
      else           cnt_q <= cnt_nx_o;
    end
  end
endmodule

// File: rtl/sc_edge_demod.sv
`timescale 1ns/1ps
module sc_edge_demod
  import sc_demod_pkg::*;
#(
  parameter int unsigned OFS_TICKS   = 490,
  parameter int unsigned WIN_TICKS   = 150,
  parameter int unsigned MAX_BITS    = 32,
  parameter int unsigned ACK_WINDOWS = 80,
  parameter int unsigned LO_EDGES    = 20,
  parameter int unsigned HI_EDGES    = 60,
  parameter int unsigned CNT_W       = 7,
  localparam int unsigned NB_W  = $clog2(MAX_BITS + 1),
  localparam int unsigned IDX_W = $clog2(((ACK_WINDOWS > MAX_BITS) ? ACK_WINDOWS : MAX_BITS) + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                start_i,
  input  logic                ack_mode_i,
  input  logic [NB_W-1:0]     nbits_i,
  input  logic [MAX_BITS-1:0] key_i,
  input  logic                rx_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [MAX_BITS-1:0] data_o,
  output logic                ack_hit_o,
  output logic                ack_miss_o,
  output logic [IDX_W-1:0]    ack_periods_o
);
  localparam logic [CNT_W-1:0] LO_C     = CNT_W'(LO_EDGES);
  localparam logic [CNT_W-1:0] HI_C     = CNT_W'(HI_EDGES);
  localparam logic [IDX_W-1:0] ACK_LAST = IDX_W'(ACK_WINDOWS - 1);

  rx_state_e           state_q;
  logic [MAX_BITS-1:0] data_q;
  logic [IDX_W-1:0]    n_q, idx_q, periods_q;
  logic                ack_q, hit_q, miss_q, done_q;

  logic                in_win, ofs_end, win_end, run, is_one;
  logic [CNT_W-1:0]    cnt_nx;
  logic [IDX_W-1:0]    n_clamp;
  logic [MAX_BITS-1:0] bit_sel;

  function automatic logic [MAX_BITS-1:0] low_mask(input logic [IDX_W-1:0] n);
    logic [MAX_BITS-1:0] m;
    for (int i = 0; i < MAX_BITS; i++) m[i] = (IDX_W'(i) < n);
    return m;
  endfunction

  assign run     = (state_q != ST_IDLE);
  assign n_clamp = (nbits_i > NB_W'(MAX_BITS)) ? IDX_W'(MAX_BITS) : IDX_W'(nbits_i);
  assign is_one  = (cnt_nx > LO_C) && (cnt_nx < HI_C);
  assign bit_sel = MAX_BITS'(1) << idx_q;

  sc_win_timer #(
    .OFS_TICKS(OFS_TICKS),
    .WIN_TICKS(WIN_TICKS)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_i),
    .run_i    (run),
    .tick_i   (tick_i),
    .in_win_o (in_win),
    .ofs_end_o(ofs_end),
    .win_end_o(win_end)
  );

  sc_edge_count #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_i),
    .tick_i   (tick_i),
    .rx_i     (rx_i),
    .en_i     (in_win),
    .win_end_i(win_end),
    .cnt_nx_o (cnt_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      data_q    <= '0;
      n_q       <= '0;
      idx_q     <= '0;
      periods_q <= '0;
      ack_q     <= 1'b0;
      hit_q     <= 1'b0;
      miss_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        state_q   <= ST_OFS;
        data_q    <= ack_mode_i ? '0 : (key_i & low_mask(n_clamp));
        n_q       <= n_clamp;
        idx_q     <= '0;
        periods_q <= '0;
        ack_q     <= ack_mode_i;
        hit_q     <= 1'b0;
        miss_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_OFS: if (ofs_end) begin
            if (!ack_q && n_q == '0) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_WIN;
            end
          end
          ST_WIN: if (win_end) begin
            idx_q <= idx_q + 1'b1;
            if (ack_q) begin
              if (is_one) begin
                hit_q     <= 1'b1;
                periods_q <= idx_q + 1'b1;
                state_q   <= ST_IDLE;
                done_q    <= 1'b1;
              end else if (idx_q == ACK_LAST) begin
                miss_q  <= 1'b1;
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end
            end else begin
              if (is_one) data_q <= data_q ^ bit_sel;
              if (idx_q == n_q - 1'b1) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign busy_o        = run;
  assign done_o        = done_q;
  assign data_o        = data_q;
  assign ack_hit_o     = hit_q;
  assign ack_miss_o    = miss_q;
  assign ack_periods_o = periods_q;
endmodule

// File: rtl/sc_demod_chk.sv
`timescale 1ns/1ps
module sc_demod_chk #(
  parameter int unsigned MAX_BITS    = 32,
  parameter int unsigned ACK_WINDOWS = 80,
  parameter int unsigned IDX_W       = 7
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                busy_o,
  input logic                done_o,
  input logic [MAX_BITS-1:0] data_o,
  input logic                ack_hit_o,
  input logic                ack_miss_o,
  input logic [IDX_W-1:0]    ack_periods_o,
  input logic                ack_q,
  input logic [IDX_W-1:0]    n_q
);
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_idle_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r2_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));

  a_r9_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_hit_o && ack_miss_o));

  a_r8_period_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_hit_o |-> (ack_periods_o >= IDX_W'(1) && ack_periods_o <= IDX_W'(ACK_WINDOWS)));

  a_r5_high_bits_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ack_q) |-> ((data_o >> n_q) == '0));

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(data_o));
endmodule

bind sc_edge_demod sc_demod_chk #(
  .MAX_BITS   (MAX_BITS),
  .ACK_WINDOWS(ACK_WINDOWS),
  .IDX_W      (IDX_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .data_o       (data_o),
  .ack_hit_o    (ack_hit_o),
  .ack_miss_o   (ack_miss_o),
  .ack_periods_o(ack_periods_o),
  .ack_q        (ack_q),
  .n_q          (n_q)
);

// File: tb/sc_edge_demod_tb.sv
`timescale 1ns/1ps
module sc_edge_demod_tb_top;
  localparam int OFS = 490;
  localparam int WIN = 150;
  localparam int NACK = 80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        start = 1'b0;
  logic        ackm = 1'b0;
  logic [5:0]  nbits = '0;
  logic [31:0] key = '0;
  logic        rx = 1'b0;
  logic        busy, done, hit, miss;
  logic [31:0] data;
  logic [6:0]  periods;

  int    edges[NACK];
  int    n_checks = 0;
  int    n_fail = 0;
  longint cyc = 0;

  always #2.5 clk = ~clk;

  sc_edge_demod dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start), .ack_mode_i(ackm),
    .nbits_i(nbits), .key_i(key), .rx_i(rx), .busy_o(busy), .done_o(done),
    .data_o(data), .ack_hit_o(hit), .ack_miss_o(miss), .ack_periods_o(periods)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      chk(1'b0, "watchdog", "run length", cyc, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  function automatic bit one_of(input int e);
    return (e > 20) && (e < 60);
  endfunction

  function automatic int clampn(input int n);
    return (n > 32) ? 32 : n;
  endfunction

  function automatic logic [31:0] exp_data(input int n, input logic [31:0] k);
    logic [31:0] d = '0;
    for (int i = 0; i < clampn(n); i++) d[i] = k[i] ^ one_of(edges[i]);
    return d;
  endfunction

  function automatic int exp_hit();
    for (int i = 0; i < NACK; i++) if (one_of(edges[i])) return i;
    return -1;
  endfunction

  // drives one reception; lat = posedges after start sampled until done seen
  task automatic run_frame(input int n_req, input bit am, input logic [31:0] k,
                           input int hold, output int lat);
    @(negedge clk);
    start = 1'b1; nbits = 6'(n_req); ackm = am; key = k; rx = 1'b0; tick = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = -1;
    for (int c = 1; c <= 20000; c++) begin
      int t;
      tick = (c > hold);
      t = c - hold;
      if (t > OFS) begin
        int w = (t - OFS - 1) / WIN;
        int j = (t - OFS - 1) % WIN + 1;
        if (w < NACK && j <= edges[w]) rx = ~rx;
      end
      @(posedge clk); #1;
      if (done) begin lat = c; break; end
      @(negedge clk);
    end
    tick = 1'b1;
  endtask

  task automatic after_done();
    @(posedge clk); #1;
    chk(!done, "R11", "done width", done, 0);
    chk(!busy, "R11", "busy after done", busy, 0);
  endtask

  task automatic normal_frame(input int n, input logic [31:0] k, input int hold, input string req);
    int lat;
    run_frame(n, 1'b0, k, hold, lat);
    chk(lat == hold + OFS + clampn(n) * WIN, "R2", "latency", lat, hold + OFS + clampn(n) * WIN);
    chk(data == exp_data(n, k), req, "data", data, exp_data(n, k));
    after_done();
  endtask

  task automatic ack_frame(input string req);
    int lat, h, el;
    run_frame(0, 1'b1, 32'h0, 0, lat);
    h = exp_hit();
    el = (h < 0) ? OFS + NACK * WIN : OFS + (h + 1) * WIN;
    chk(lat == el, req, "ack latency", lat, el);
    chk(hit == (h >= 0), req, "ack hit flag", hit, h >= 0);
    chk(miss == (h < 0), req, "ack miss flag", miss, h < 0);
    if (h >= 0) chk(periods == 7'(h + 1), req, "ack periods", periods, h + 1);
    after_done();
  endtask

  initial begin
    logic [31:0] held;
    int dcount;
    void'($urandom(32'd4242));
    repeat (5) @(posedge clk);
    #1;
    // R1 reset state
    chk(!busy && !done, "R1", "busy/done at reset", {busy, done}, 0);
    chk(data == '0, "R1", "data at reset", data, 0);
    chk(!hit && !miss && periods == '0, "R1", "ack outputs at reset", {hit, miss, periods}, 0);
    @(negedge clk); rst_n = 1'b1; tick = 1'b1;

    // R3 band edges, R4 saturation: counts 0,21,20,59,60,42,1,149 -> 0x2A
    foreach (edges[i]) edges[i] = 0;
    edges[0] = 0; edges[1] = 21; edges[2] = 20; edges[3] = 59;
    edges[4] = 60; edges[5] = 42; edges[6] = 1; edges[7] = 149;
    normal_frame(8, 32'h0, 0, "R3");
    chk(data == 32'h0000_002A, "R3", "band bounds word", data, 32'h2A);
    chk(data[7] == 1'b0, "R4", "149 changes saturate to 0", data[7], 0);

    // R5 clamp to 32, R6 key seed
    foreach (edges[i]) edges[i] = $urandom_range(0, 149);
    normal_frame(40, $urandom, 0, "R5");

    // R2 zero bits
    normal_frame(0, 32'hFFFF_FFFF, 0, "R2");
    chk(data == '0, "R2", "zero-bit word", data, 0);

    // R7 silent input keeps masked key
    foreach (edges[i]) edges[i] = 0;
    normal_frame(12, 32'hDEAD_BEEF, 0, "R7");
    chk(data == 32'h0000_0EEF, "R7", "silent masked key", data, 32'hEEF);

    // R8 early hit, later ones ignored
    foreach (edges[i]) edges[i] = 0;
    edges[2] = 60; edges[5] = 42; edges[9] = 42;
    ack_frame("R8");

    // R9 timeout
    foreach (edges[i]) edges[i] = 0;
    ack_frame("R9");

    // R10 ticks held off for 600 cycles
    foreach (edges[i]) edges[i] = 0;
    edges[0] = 30;
    normal_frame(2, 32'h0000_0003, 600, "R10");

    // R10 restart mid-frame
    @(negedge clk); start = 1'b1; nbits = 6'd5; ackm = 1'b0; key = 32'h1F; rx = 1'b0;
    @(negedge clk); start = 1'b0;
    dcount = 0;
    repeat (1000) begin @(posedge clk); #1; if (done) dcount++; end
    chk(dcount == 0 && busy, "R10", "no done before restart", dcount, 0);
    foreach (edges[i]) edges[i] = 0;
    edges[1] = 40;
    normal_frame(3, 32'h5, 0, "R10");

    // R10 idle input ignored
    held = data;
    dcount = 0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk); rx = ~rx;
      @(posedge clk); #1; if (done) dcount++;
    end
    chk(data == held && dcount == 0, "R10", "idle rx ignored", data, held);

    // random normal frames
    for (int f = 0; f < 6; f++) begin
      foreach (edges[i]) edges[i] = $urandom_range(0, 149);
      normal_frame($urandom_range(1, 32), $urandom, 0, "R6");
    end

    // random acknowledge frames
    for (int f = 0; f < 2; f++) begin
      int k = $urandom_range(0, NACK - 1);
      foreach (edges[i]) edges[i] = $urandom_range(0, 149);
      for (int i = 0; i < k; i++) edges[i] = ($urandom_range(0, 1) != 0) ? $urandom_range(0, 20) : $urandom_range(60, 149);
      edges[k] = $urandom_range(21, 59);
      ack_frame("R8");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule